// File: doc/BRIEF.md
# Exception Stack Frame Sequencer

This block handles the memory side of exception entry and exception return for a 68k-style processor core. When the core takes an exception, it gives the sequencer the vector number, a frame format code, the status word and return address in force before the exception, an optional fault address, and whether the event is a hardware interrupt and at which level. The sequencer then builds the stack frame one 16-bit word at a time over a request/acknowledge memory port. It updates the stack registers and the live status word, and loads the handler address from the vector table.

On a return from exception, the sequencer pops the status word, the return address and, in the extended mode, the format/vector word. It then moves the stack pointer past the format-specific extra bytes. A throwaway-format frame makes it continue with a second frame, which may sit on the other supervisor stack. An interrupt taken while the master-stack bit is set builds two frames, one on each stack. A mode input selects the original layout, which has no format/vector word.

The core must hold every input steady while `busy` is high. Results are valid in the cycle in which `done` pulses.

Top module: `exc_frame_seq`

## Requirements
- R1: In extended mode (`orig_mode`=0), an entry frame holds the following words, reading upward from the final stack pointer: the old status word, return PC bits 31:16, return PC bits 15:0, and then the format/vector word. The format/vector word carries the format code in bits 15:12 and the vector number times 4 in bits 11:0.
- R2: The extra words sit above the format/vector word, and each longword is stored high half at the lower address. Formats 2 and 3 add the fault address (2 words). Format 4 adds the fault address and then the PC above it (4 words). Formats 0 and 1 add nothing.
- R3: In original mode (`orig_mode`=1), entry writes no format/vector word. The extra words follow directly after the PC.
- R4: After entry, `sr_o` is the old status word with bit 13 (supervisor) set and bit 15 (trace) cleared. For a hardware interrupt, bits 10:8 are also replaced by `irq_lvl`. All other bits are kept.
- R5: Bit 12 of the status word selects the active stack: 1 selects master and 0 selects interrupt. On entry, bit 0 of the active stack pointer is cleared before the first push (parameter `ODD_SP_OK`=0). The final frame address is returned on that stack's output, and the other stack output equals its input.
- R6: In extended mode, a hardware interrupt with old bit 12 set pushes a format 0 frame on the master stack, then clears bit 12, then pushes a format 1 frame on the interrupt stack. The format 1 frame's stored status word has bit 12 still set.
- R7: After entry, `pc_o` is the longword at `vec_base + 4*vec`, read as two words with the high word first.
- R8: Entry writes go out at strictly decreasing addresses. Each request keeps its address, direction and write data unchanged until acknowledged.
- R9: On return, the block reads the status word, then the PC, then (extended mode only) the format/vector word, starting at the active stack pointer. The pointer then advances by 6 in original mode, or by 8 plus 0, 4, 8 or 52 for formats 0, 2/3, 4 or 7.
- R10: On return, format 1 writes the advanced pointer back to the stack selected by the live bit 12. It then makes the popped status word live and continues unwinding from the stack that the new bit 12 selects.
- R11: A return that meets format 5, 6 or 8-15 in extended mode pulses `fmt_err` together with `done`, and leaves all four result outputs equal to their inputs. Entry never raises `fmt_err`.
- R12: `busy` rises in the cycle after `enter` or `leave` is accepted and is low in the cycle in which `done` pulses for one cycle. After reset, `busy`, `done` and `mem_req` are low.
- R13: On return, the final pointer goes to the stack selected by bit 12 of the status word that was live before the last pop. `sr_o` becomes the popped status word and `pc_o` the popped PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enter | input | 1 | Start exception entry (wins over `leave`) |
| leave | input | 1 | Start return from exception |
| orig_mode | input | 1 | 1 selects the layout without a format/vector word |
| vec | input | VW | Exception vector number |
| fmt | input | 4 | Frame format code for entry |
| sr_in | input | 16 | Status word before the operation |
| pc_in | input | 32 | Return PC for entry |
| fault_in | input | 32 | Fault or instruction address for formats 2-4 |
| hw_irq | input | 1 | Entry is a hardware interrupt |
| irq_lvl | input | 3 | Pending interrupt level |
| istk_in | input | 32 | Interrupt stack pointer |
| mstk_in | input | 32 | Master stack pointer |
| vec_base | input | 32 | Vector table base address |
| mem_req | output | 1 | Memory word request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 16 | Write data |
| mem_ack | input | 1 | Request completed this cycle |
| mem_rdata | input | 16 | Read data, valid with `mem_ack` |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| fmt_err | output | 1 | Unsupported format met on return |
| istk_o | output | 32 | Resulting interrupt stack pointer |
| mstk_o | output | 32 | Resulting master stack pointer |
| sr_o | output | 16 | Resulting live status word |
| pc_o | output | 32 | Handler address or popped PC |

## Verification
The bench builds the block with its defaults, `ODD_SP_OK`=0 and an 8-bit vector. This means odd stack pointers must be evened before the first push, and vector offsets reach 1020 bytes above a movable table base. Entry is swept over both layouts, formats 0 to 4, interrupt or not, and both settings of the master bit, with odd and even pointers and an acknowledge latency of 0 to 2 cycles. Return is swept over all sixteen format codes in both layouts, plus throwaway frames that stay on one stack and frames that switch stacks.

// File: rtl/exc_frame_seq.sv
module exc_frame_seq #(
  parameter bit ODD_SP_OK = 1'b0,
  parameter int VW        = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enter,
  input  logic          leave,
  input  logic          orig_mode,
  input  logic [VW-1:0] vec,
  input  logic [3:0]    fmt,
  input  logic [15:0]   sr_in,
  input  logic [31:0]   pc_in,
  input  logic [31:0]   fault_in,
  input  logic          hw_irq,
  input  logic [2:0]    irq_lvl,
  input  logic [31:0]   istk_in,
  input  logic [31:0]   mstk_in,
  input  logic [31:0]   vec_base,
  output logic          mem_req,
  output logic          mem_we,
  output logic [31:0]   mem_addr,
  output logic [15:0]   mem_wdata,
  input  logic          mem_ack,
  input  logic [15:0]   mem_rdata,
  output logic          busy,
  output logic          done,
  output logic          fmt_err,
  output logic [31:0]   istk_o,
  output logic [31:0]   mstk_o,
  output logic [15:0]   sr_o,
  output logic [31:0]   pc_o
);
  localparam int OFSW = VW + 2;

  typedef enum logic [2:0] {S_IDLE, S_PUSH, S_VEC, S_POP, S_DEC} st_t;

  st_t         st;
  logic [31:0] sp, rpc;
  logic [15:0] lsr, fsr, rsr, rfv;
  logic [3:0]  ffmt;
  logic [2:0]  k;
  logic        dual;

  function automatic logic [3:0] nwords(input logic [3:0] f, input logic e);
    logic [3:0] n;
    n = e ? 4'd4 : 4'd3;
    if (f == 4'd2 || f == 4'd3) n = n + 4'd2;
    else if (f == 4'd4) n = n + 4'd4;
    return n;
  endfunction

  function automatic logic [31:0] even(input logic [31:0] a);
    return ODD_SP_OK ? a : {a[31:1], 1'b0};
  endfunction

  wire        ext     = !orig_mode;
  wire        go_dual = ext && hw_irq && sr_in[12];
  wire [3:0]  f_first = go_dual ? 4'd0 : fmt;
  wire [3:0]  nw      = nwords(ffmt, ext);
  wire [31:0] base    = sp - {27'd0, nw, 1'b0};
  wire [2:0]  xi      = k - (ext ? 3'd4 : 3'd3);
  wire [3:0]  rf      = rfv[15:12];
  wire [31:0] rsp     = sp + (ext ? 32'd8 : 32'd6);
  wire        rf_ok   = !ext || rf inside {4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd7};
  wire [31:0] vaddr   = vec_base + {{(30-VW){1'b0}}, vec, 2'b00} + {30'd0, k[0], 1'b0};

  logic [15:0] pword, nsr;
  logic [31:0] skip;

  always_comb begin
    pword = fsr;
    if (k == 3'd1) pword = pc_in[31:16];
    else if (k == 3'd2) pword = pc_in[15:0];
    else if (k == 3'd3 && ext) pword = {ffmt, 12'({vec, 2'b00})};
    else if (k != 3'd0) begin
      case (xi)
        3'd0:    pword = fault_in[31:16];
        3'd1:    pword = fault_in[15:0];
        3'd2:    pword = pc_in[31:16];
        default: pword = pc_in[15:0];
      endcase
    end
  end

  always_comb begin
    nsr     = sr_in;
    nsr[13] = 1'b1;
    nsr[15] = 1'b0;
    if (hw_irq) nsr[10:8] = irq_lvl;
  end

  always_comb begin
    skip = '0;
    if (ext) begin
      case (rf)
        4'd2, 4'd3: skip = 32'd4;
        4'd4:       skip = 32'd8;
        4'd7:       skip = 32'd52;
        default:    skip = '0;
      endcase
    end
  end

  assign mem_req   = (st == S_PUSH) || (st == S_VEC) || (st == S_POP);
  assign mem_we    = (st == S_PUSH);
  assign mem_addr  = (st == S_PUSH) ? base + {28'd0, k, 1'b0} :
                     (st == S_VEC)  ? vaddr : sp + {28'd0, k, 1'b0};
  assign mem_wdata = pword;
  assign busy      = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; sp <= '0; rpc <= '0; lsr <= '0; fsr <= '0; rsr <= '0;
      rfv <= '0; ffmt <= '0; k <= '0; dual <= 1'b0; done <= 1'b0;
      fmt_err <= 1'b0; istk_o <= '0; mstk_o <= '0; sr_o <= '0; pc_o <= '0;
    end else begin
      done    <= 1'b0;
      fmt_err <= 1'b0;
      case (st)
        S_IDLE: begin
          if (enter) begin
            dual   <= go_dual;
            ffmt   <= f_first;
            k      <= 3'(nwords(f_first, ext) - 4'd1);
            fsr    <= sr_in;
            lsr    <= nsr;
            sp     <= even(sr_in[12] ? mstk_in : istk_in);
            istk_o <= istk_in;
            mstk_o <= mstk_in;
            st     <= S_PUSH;
          end else if (leave) begin
            lsr    <= sr_in;
            sp     <= sr_in[12] ? mstk_in : istk_in;
            istk_o <= istk_in;
            mstk_o <= mstk_in;
            k      <= '0;
            st     <= S_POP;
          end
        end
        S_PUSH: if (mem_ack) begin
          if (k != 3'd0) k <= k - 3'd1;
          else begin
            if (lsr[12]) mstk_o <= base; else istk_o <= base;
            if (dual) begin
              dual    <= 1'b0;
              fsr     <= lsr;
              lsr[12] <= 1'b0;
              ffmt    <= 4'd1;
              sp      <= even(istk_o);
              k       <= 3'(nwords(4'd1, ext) - 4'd1);
            end else begin
              k  <= '0;
              st <= S_VEC;
            end
          end
        end
        S_VEC: if (mem_ack) begin
          if (k == 3'd0) begin
            rpc[31:16] <= mem_rdata;
            k          <= 3'd1;
          end else begin
            pc_o <= {rpc[31:16], mem_rdata};
            sr_o <= lsr;
            done <= 1'b1;
            st   <= S_IDLE;
          end
        end
        S_POP: if (mem_ack) begin
          case (k)
            3'd0:    rsr        <= mem_rdata;
            3'd1:    rpc[31:16] <= mem_rdata;
            3'd2:    rpc[15:0]  <= mem_rdata;
            default: rfv        <= mem_rdata;
          endcase
          if (k == (ext ? 3'd3 : 3'd2)) st <= S_DEC;
          else k <= k + 3'd1;
        end
        S_DEC: begin
          if (!rf_ok) begin
            fmt_err <= 1'b1;
            done    <= 1'b1;
            istk_o  <= istk_in;
            mstk_o  <= mstk_in;
            sr_o    <= sr_in;
            pc_o    <= pc_in;
            st      <= S_IDLE;
          end else begin
            if (lsr[12]) mstk_o <= rsp + skip; else istk_o <= rsp + skip;
            lsr <= rsr;
            if (ext && rf == 4'd1) begin
              sp <= (rsr[12] == lsr[12]) ? rsp : (rsr[12] ? mstk_o : istk_o);
              k  <= '0;
              st <= S_POP;
            end else begin
              sr_o <= rsr;
              pc_o <= rpc;
              done <= 1'b1;
              st   <= S_IDLE;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/exc_frame_seq_chk.sv
module exc_frame_seq_chk #(
  parameter bit ODD_SP_OK = 1'b0
) (
  input logic        clk,
  input logic        rst_n,
  input logic        enter,
  input logic        leave,
  input logic        busy,
  input logic        done,
  input logic        fmt_err,
  input logic        mem_req,
  input logic        mem_we,
  input logic        mem_ack,
  input logic [31:0] mem_addr,
  input logic [15:0] mem_wdata,
  input logic [15:0] sr_o
);
  logic was_entry;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) was_entry <= 1'b0;
    else if (!busy && (enter || leave)) was_entry <= enter;
  end

  a_r8_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) &&
                            (!mem_we || $stable(mem_wdata)));

  a_r5_even_push: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we && !ODD_SP_OK |-> !mem_addr[0]);

  a_r12_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r12_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(enter || leave));

  a_r11_err_on_return: assert property (@(posedge clk) disable iff (!rst_n)
    fmt_err |-> done && !was_entry);

  a_r4_sup_after_entry: assert property (@(posedge clk) disable iff (!rst_n)
    done && was_entry |-> sr_o[13] && !sr_o[15]);
endmodule

bind exc_frame_seq exc_frame_seq_chk #(.ODD_SP_OK(ODD_SP_OK)) u_chk (
  .clk(clk), .rst_n(rst_n), .enter(enter), .leave(leave), .busy(busy),
  .done(done), .fmt_err(fmt_err), .mem_req(mem_req), .mem_we(mem_we),
  .mem_ack(mem_ack), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .sr_o(sr_o)
);

// File: tb/test_exc_frame_seq.sv
module test_exc_frame_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        enter = 0, leave = 0, orig_mode = 0, hw_irq = 0;
  logic [7:0]  vec = 0;
  logic [3:0]  fmt = 0;
  logic [15:0] sr_in = 0;
  logic [31:0] pc_in = 0, fault_in = 0, istk_in = 0, mstk_in = 0, vec_base = 0;
  logic [2:0]  irq_lvl = 0;
  logic        mem_req, mem_we, mem_ack, busy, done, fmt_err;
  logic [31:0] mem_addr, istk_o, mstk_o, pc_o;
  logic [15:0] mem_wdata, mem_rdata, sr_o;

  exc_frame_seq i_exc_frame_seq (
    .clk(clk), .rst_n(rst_n), .enter(enter), .leave(leave), .orig_mode(orig_mode),
    .vec(vec), .fmt(fmt), .sr_in(sr_in), .pc_in(pc_in), .fault_in(fault_in),
    .hw_irq(hw_irq), .irq_lvl(irq_lvl), .istk_in(istk_in), .mstk_in(mstk_in),
    .vec_base(vec_base), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata), .busy(busy),
    .done(done), .fmt_err(fmt_err), .istk_o(istk_o), .mstk_o(mstk_o),
    .sr_o(sr_o), .pc_o(pc_o)
  );

  int checks = 0, fails = 0, lat = 0;

  logic [15:0] mem [0:4095];
  logic        tb_clr = 0, tb_we = 0;
  logic [31:0] tb_a = 0;
  logic [15:0] tb_d = 0;
  logic [31:0] prev_wa;
  logic        order_bad;
  int          wr_cnt = 0, wait_c = 0;

  function automatic logic [15:0] vtab(input logic [31:0] a);
    return a[15:0] ^ 16'h5A5A;
  endfunction

  function automatic logic [15:0] rd(input logic [31:0] a);
    return mem[a[12:1]];
  endfunction

  always @(posedge clk) begin
    if (tb_clr) begin prev_wa <= 32'hFFFF_FFFF; order_bad <= 1'b0; wr_cnt <= 0; end
    if (tb_we) mem[tb_a[12:1]] <= tb_d;
    if (!rst_n) begin
      mem_ack <= 1'b0; wait_c <= 0;
    end else if (mem_ack) mem_ack <= 1'b0;
    else if (mem_req) begin
      if (wait_c >= lat) begin
        mem_ack <= 1'b1; wait_c <= 0;
        if (mem_we) begin
          mem[mem_addr[12:1]] <= mem_wdata;
          if (mem_addr >= prev_wa) order_bad <= 1'b1;
          prev_wa <= mem_addr;
          wr_cnt  <= wr_cnt + 1;
        end else mem_rdata <= (mem_addr < 32'h1000) ? vtab(mem_addr) : mem[mem_addr[12:1]];
      end else wait_c <= wait_c + 1;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  task automatic put(input logic [31:0] a, input logic [15:0] d);
    tb_we = 1; tb_a = a; tb_d = d;
    @(negedge clk);
    tb_we = 0;
  endtask

  task automatic run_op(input bit is_entry);
    int n;
    tb_clr = 1;
    @(negedge clk);
    tb_clr = 0;
    if (is_entry) enter = 1; else leave = 1;
    @(negedge clk);
    enter = 0; leave = 0;
    chk("R12", "busy after start", 32'(busy), 32'd1);
    n = 0;
    while (!done && n < 400) begin @(negedge clk); n++; end
    chk("R12", "done reached", 32'(done), 32'd1);
    chk("R12", "busy low at done", 32'(busy), 32'd0);
  endtask

  function automatic int xwords(input logic [3:0] f);
    if (f == 2 || f == 3) return 2;
    if (f == 4) return 4;
    return 0;
  endfunction

  task automatic chk_frame(input logic [31:0] b, input logic [3:0] f, input logic [15:0] s,
                           input bit e, input logic [7:0] v);
    logic [31:0] x;
    chk("R1", "stacked sr", 32'(rd(b)), 32'(s));
    chk("R1", "stacked pc hi", 32'(rd(b + 2)), 32'(pc_in[31:16]));
    chk("R1", "stacked pc lo", 32'(rd(b + 4)), 32'(pc_in[15:0]));
    if (e) chk("R1", "format/vector word", 32'(rd(b + 6)), 32'({f, 2'b00, v, 2'b00}));
    x = b + (e ? 32'd8 : 32'd6);
    if (f == 2 || f == 3 || f == 4) begin
      chk(e ? "R2" : "R3", "fault hi", 32'(rd(x)), 32'(fault_in[31:16]));
      chk(e ? "R2" : "R3", "fault lo", 32'(rd(x + 2)), 32'(fault_in[15:0]));
    end
    if (f == 4) begin
      chk("R2", "fmt4 pc hi", 32'(rd(x + 4)), 32'(pc_in[31:16]));
      chk("R2", "fmt4 pc lo", 32'(rd(x + 6)), 32'(pc_in[15:0]));
    end
  endtask

  task automatic do_entry(input bit orig, input logic [3:0] f, input bit hw, input bit m,
                          input logic [7:0] v, input logic [2:0] lvl, input bit odd);
    bit e, dl;
    logic [15:0] s, ns;
    logic [31:0] sp0, b, b2, a;
    int n;
    e = !orig; dl = e && hw && m;
    s = 16'h8715 | (m ? 16'h1000 : 16'h0000);
    orig_mode = orig; fmt = f; hw_irq = hw; irq_lvl = lvl; vec = v; sr_in = s;
    pc_in = 32'h1234_5670 + 32'(v); fault_in = 32'hFA00_0000 | (32'(v) << 4);
    istk_in = 32'h1800 | 32'(odd); mstk_in = 32'h1C00 | 32'(odd);
    vec_base = v[0] ? 32'h200 : 32'h0;
    run_op(1);
    ns = s; ns[13] = 1'b1; ns[15] = 1'b0;
    if (hw) ns[10:8] = lvl;
    chk("R8", "write order", 32'(order_bad), 32'd0);
    chk("R11", "no fmt_err on entry", 32'(fmt_err), 32'd0);
    if (dl) begin
      b = 32'h1C00 - 32'd8; b2 = 32'h1800 - 32'd8;
      chk_frame(b, 4'd0, s, 1'b1, v);
      chk_frame(b2, 4'd1, ns, 1'b1, v);
      chk("R6", "master stack", mstk_o, b);
      chk("R6", "interrupt stack", istk_o, b2);
      chk("R6", "write count", 32'(wr_cnt), 32'd8);
      ns[12] = 1'b0;
      chk("R6", "live sr master bit", 32'(sr_o), 32'(ns));
    end else begin
      n = 3 + int'(e) + xwords(f);
      sp0 = m ? 32'h1C00 : 32'h1800;
      b = sp0 - 32'(2 * n);
      chk_frame(b, f, s, e, v);
      chk(orig ? "R3" : "R2", "write count", 32'(wr_cnt), 32'(n));
      chk("R5", "active stack", m ? mstk_o : istk_o, b);
      chk("R5", "other stack", m ? istk_o : mstk_o, m ? istk_in : mstk_in);
      chk("R4", "live sr", 32'(sr_o), 32'(ns));
    end
    a = vec_base + 32'(v) * 4;
    chk("R7", "handler pc", pc_o, {vtab(a), vtab(a + 2)});
  endtask

  task automatic do_ret(input bit orig, input logic [3:0] f, input bit m);
    logic [31:0] sp0, adv;
    logic [15:0] s;
    bit bad;
    sp0 = m ? 32'h1C00 : 32'h1800;
    s = 16'h0300 | 16'(f) | (m ? 16'h0000 : 16'h1000);
    put(sp0, s); put(sp0 + 2, 16'hBEE0 ^ 16'(f)); put(sp0 + 4, 16'h4000 + 16'(f));
    put(sp0 + 6, {f, 12'h0A8});
    orig_mode = orig; sr_in = 16'h2000 | (m ? 16'h1000 : 16'h0000); pc_in = 32'hDEAD_0000;
    istk_in = 32'h1800; mstk_in = 32'h1C00;
    run_op(0);
    bad = !orig && !(f inside {4'd0, 4'd2, 4'd3, 4'd4, 4'd7});
    if (bad) begin
      chk("R11", "fmt_err", 32'(fmt_err), 32'd1);
      chk("R11", "istk kept", istk_o, istk_in);
      chk("R11", "mstk kept", mstk_o, mstk_in);
      chk("R11", "sr kept", 32'(sr_o), 32'(sr_in));
      chk("R11", "pc kept", pc_o, pc_in);
    end else begin
      adv = orig ? 32'd6 : 32'd8;
      if (!orig) adv += (f == 2 || f == 3) ? 32'd4 : (f == 4) ? 32'd8 : (f == 7) ? 32'd52 : 32'd0;
      chk("R11", "no fmt_err", 32'(fmt_err), 32'd0);
      chk("R9", "advanced stack", m ? mstk_o : istk_o, sp0 + adv);
      chk("R13", "other stack untouched", m ? istk_o : mstk_o, m ? istk_in : mstk_in);
      chk("R13", "popped sr", 32'(sr_o), 32'(s));
      chk("R13", "popped pc", pc_o, {16'hBEE0 ^ 16'(f), 16'h4000 + 16'(f)});
    end
  endtask

  task automatic do_throw(input bit same);
    logic [15:0] s1, s2;
    logic [31:0] f2;
    s1 = 16'h2005 | (same ? 16'h0000 : 16'h1000);
    s2 = 16'h0011;
    f2 = same ? 32'h1808 : 32'h1C00;
    put(32'h1800, s1); put(32'h1802, 16'h1111); put(32'h1804, 16'h2222); put(32'h1806, 16'h1040);
    put(f2, s2); put(f2 + 2, 16'h3333); put(f2 + 4, 16'h4444);
    put(f2 + 6, same ? 16'h2040 : 16'h0040);
    orig_mode = 0; sr_in = 16'h2000; pc_in = 32'h0;
    istk_in = 32'h1800; mstk_in = 32'h1C00;
    run_op(0);
    chk("R10", "no fmt_err", 32'(fmt_err), 32'd0);
    chk("R10", "final sr", 32'(sr_o), 32'(s2));
    chk("R10", "final pc", pc_o, 32'h3333_4444);
    if (same) begin
      chk("R10", "istk same stack", istk_o, 32'h1814);
      chk("R10", "mstk untouched", mstk_o, 32'h1C00);
    end else begin
      chk("R10", "istk after throwaway", istk_o, 32'h1808);
      chk("R10", "mstk after second frame", mstk_o, 32'h1C08);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R12 watchdog: actual 150000 cycles expected completion");
    summary();
    $finish;
  end

  initial begin
    int op;
    repeat (3) @(negedge clk);
    chk("R12", "reset busy", 32'(busy), 32'd0);
    chk("R12", "reset done", 32'(done), 32'd0);
    chk("R12", "reset mem_req", 32'(mem_req), 32'd0);
    rst_n = 1;
    @(negedge clk);
    op = 0;
    for (int o = 0; o < 2; o++)
      for (int f = 0; f < 5; f++)
        for (int h = 0; h < 2; h++)
          for (int m = 0; m < 2; m++) begin
            lat = op % 3; op++;
            do_entry(o[0], 4'(f), h[0], m[0], 8'((f * 37 + h * 101 + m * 7 + o * 200) & 255),
                     3'((f + h + m + 1) % 8), 1'((f + m) & 1));
          end
    for (int o = 0; o < 2; o++)
      for (int f = 0; f < 16; f++) begin
        if (o == 0 && f == 1) continue;
        lat = op % 3; op++;
        do_ret(o[0], 4'(f), f[0]);
      end
    lat = 1; do_throw(1'b1);
    lat = 2; do_throw(1'b0);
    summary();
    $finish;
  end
endmodule